// File: doc/BRIEF.md
# Fixed-Priority Channel Arbiter with Transfer-Boundary Arbitration

This block chooses which of four DMA channels owns a shared transfer engine. Each channel presents a level-sensitive request line. The engine signals the end of a transfer with a one-cycle pulse that marks the final data item. The arbiter drives a one-hot grant, the binary index of the granted channel, and a busy flag.

Priority is fixed: the lowest-numbered channel wins. Once a transfer starts, its grant cannot be taken away. A request that shows up while a transfer is running, even one from a more urgent channel, waits until the final-data pulse. On the clock edge that samples that pulse, the arbiter picks among the channels requesting at that moment. The chosen channel owns the engine from the next cycle, with no idle cycle between the two transfers. If nothing is pending at that edge, the arbiter goes idle.

Top module: `dma_chan_arbiter`

## Requirements
- R1: While reset is asserted (asynchronous, active low), the grant is all zeros, the index is 0 and busy is low.
- R2: When idle with no request, the grant stays all zeros and busy stays low.
- R3: A request sampled while idle produces a one-hot grant for that channel, with busy high, after the next rising clock edge.
- R4: When several channels request at the same arbitration point, the lowest-numbered one is granted. Channel 0 (request bit 0) is the highest priority and channel 3 (request bit 3) the lowest.
- R5: While busy, the grant and index do not change on any edge where the final-data pulse is low, whatever the request lines do.
- R6: On an edge where busy is high and the final-data pulse is high, a new arbitration runs over the requests sampled at that edge. The winner's grant appears right after that edge, without an idle cycle.
- R7: If no channel requests on the edge that samples the final-data pulse, the arbiter returns to idle: grant all zeros, busy low.
- R8: The index output is the binary number of the granted channel (grant bit k gives index k), and it is 0 while idle.
- R9: A final-data pulse while idle has no effect: with no request pending, the arbiter stays idle.
- R10: A channel that is still requesting when its own transfer ends competes again, and it is granted again if it is the highest pending channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | Request lines, one per channel; bit k is channel k |
| last_i | input | 1 | Final-data pulse from the transfer engine |
| grant_o | output | 4 | One-hot grant; bit k set means channel k owns the engine |
| grant_idx_o | output | 2 | Binary index of the granted channel |
| busy_o | output | 1 | High while a transfer is granted |

## Verification
All three outputs are registered. Each result is therefore due exactly one rising edge after the edge that samples the request lines and the final-data pulse. The bench drives inputs 1 ns after a rising edge and reads the outputs 1 ns after the following rising edge. Each check thus observes the decision made at the single edge in between, and never samples an output in the cycle it changes. The reset check is the exception: reset acts asynchronously, so the outputs are read 1 ns after reset falls, without waiting for an edge.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_XFER = 1'b1
    } arb_state_e;

endpackage

// File: rtl/arb_prio_pick.sv
// Fixed-priority picker: the lowest set request bit wins.
module arb_prio_pick #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] req_i,
    output logic [NUM_CH-1:0] pick_o
);

    logic [NUM_CH:0] taken;

    assign taken[0] = 1'b0;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chain
        assign pick_o[i]    = req_i[i] & ~taken[i];
        assign taken[i + 1] = taken[i] | req_i[i];
    end

endmodule

// File: rtl/arb_idx_enc.sv
// One-hot to binary index; all-zero input gives index 0.
module arb_idx_enc #(
    parameter int NUM_CH = 4,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] onehot_i,
    output logic [IDX_W-1:0]  idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (onehot_i[i]) begin
                idx_o = idx_o | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] req_i,
    input  logic              last_i,
    output logic [NUM_CH-1:0] grant_o,
    output logic [IDX_W-1:0]  grant_idx_o,
    output logic              busy_o
);

    typedef struct packed {
        arb_state_e        state;
        logic [NUM_CH-1:0] grant;
    } arb_regs_t;

    localparam arb_regs_t REGS_RESET = '{state: ARB_IDLE, grant: '0};

    arb_regs_t         regs_d, regs_q;
    logic [NUM_CH-1:0] pick;
    logic              arb_point;

    arb_prio_pick #(
        .NUM_CH (NUM_CH)
    ) i_pick (
        .req_i  (req_i),
        .pick_o (pick)
    );

    // Arbitration happens only when idle or on the final-data edge.
    assign arb_point = (regs_q.state == ARB_IDLE) || last_i;

    always_comb begin
        regs_d = regs_q;
        if (arb_point) begin
            if (|req_i) begin
                regs_d.state = ARB_XFER;
                regs_d.grant = pick;
            end else begin
                regs_d.state = ARB_IDLE;
                regs_d.grant = '0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= REGS_RESET;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign grant_o = regs_q.grant;
    assign busy_o  = (regs_q.state == ARB_XFER);

    arb_idx_enc #(
        .NUM_CH (NUM_CH)
    ) i_enc (
        .onehot_i (regs_q.grant),
        .idx_o    (grant_idx_o)
    );

    // ------------------------------------------------------------------
    // Assertions
    // ------------------------------------------------------------------
    logic [NUM_CH-1:0] below_grant;
    assign below_grant = grant_o - {{(NUM_CH-1){1'b0}}, 1'b1};

    assert_grant_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant_o) && (busy_o == (grant_o != '0)));

    assert_idle_grant_next_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && (req_i != '0)) |=> busy_o);

    assert_hold_grant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !last_i) |=> ($stable(grant_o) && $stable(grant_idx_o)));

    assert_winner_priority_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((!busy_o || last_i) && (req_i != '0)) |=>
            (((grant_o & $past(req_i)) != '0) && ((below_grant & $past(req_i)) == '0)));

    assert_release_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && last_i && (req_i == '0)) |=> !busy_o);

    assert_last_when_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && (req_i == '0)) |=> (!busy_o && (grant_o == '0)));

    assert_index_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> grant_o[grant_idx_o]);

endmodule

// File: tb/test_dma_chan_arbiter.sv
module test_dma_chan_arbiter;

    localparam int NUM_CH = 4;
    localparam int IDX_W  = 2;
    localparam int NVEC   = 15;

    // Vector layout: [13:10] requirement tag, [9:6] req, [5] last,
    // [4:1] expected grant, [0] expected busy.
    localparam logic [13:0] VECS [NVEC] = '{
        14'b0010_0000_0_0000_0, // R2  idle, nothing requested
        14'b0011_1000_0_1000_1, // R3  ch3 alone from idle
        14'b0101_1001_0_1000_1, // R5  ch0 arrives mid-transfer, must wait
        14'b0110_1001_1_0001_1, // R6  final data: ch0 wins
        14'b0101_0110_0_0001_1, // R5  requests change, grant holds
        14'b0100_0110_1_0010_1, // R4  ch1 beats ch2
        14'b0110_0100_1_0100_1, // R6  back-to-back to ch2
        14'b0111_0000_1_0000_0, // R7  nothing pending -> idle
        14'b1001_0000_1_0000_0, // R9  pulse while idle ignored
        14'b0011_1100_0_0100_1, // R3  ch2 over ch3 from idle
        14'b1010_1100_1_0100_1, // R10 ch2 still requesting, regranted
        14'b0110_1000_1_1000_1, // R6  ch3 next
        14'b0100_1111_1_0001_1, // R4  all request, ch0 wins
        14'b0100_1110_1_0010_1, // R4  ch1 next
        14'b0111_0000_1_0000_0  // R7  back to idle
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] req = '0;
    logic              last = 1'b0;
    logic [NUM_CH-1:0] grant;
    logic [IDX_W-1:0]  grant_idx;
    logic              busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dma_chan_arbiter #(
        .NUM_CH (NUM_CH)
    ) i_dma_chan_arbiter (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .req_i       (req),
        .last_i      (last),
        .grant_o     (grant),
        .grant_idx_o (grant_idx),
        .busy_o      (busy)
    );

    function automatic logic [IDX_W-1:0] idx_of(input logic [NUM_CH-1:0] g);
        logic [IDX_W-1:0] r = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (g[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    task automatic check(input int tag, input logic [NUM_CH-1:0] eg, input logic eb);
        logic [IDX_W-1:0] ei = idx_of(eg);
        checks++;
        if (grant !== eg || busy !== eb || grant_idx !== ei) begin
            errors++;
            $display("FAIL R%0d: grant=%b busy=%b idx=%0d expected grant=%b busy=%b idx=%0d",
                     tag, grant, busy, grant_idx, eg, eb, ei);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        #3;
        check(1, 4'b0000, 1'b0);
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        step();
        check(1, 4'b0000, 1'b0);

        // Vector walk: drive, one edge, check (R8 index on every check)
        for (int v = 0; v < NVEC; v++) begin
            req  = VECS[v][9:6];
            last = VECS[v][5];
            step();
            check(int'(VECS[v][13:10]), VECS[v][4:1], VECS[v][0]);
        end

        // R8: index of channel 3 while granted
        req = 4'b1000; last = 1'b0;
        step();
        check(8, 4'b1000, 1'b1);

        // R1: asynchronous reset in the middle of a transfer
        rst_n = 1'b0;
        #1;
        check(1, 4'b0000, 1'b0);
        req = 4'b0000;
        step();
        rst_n = 1'b1;
        step();
        check(2, 4'b0000, 1'b0);

        // R9: pulse while idle with a request behaves like a normal grant
        req = 4'b0010; last = 1'b1;
        step();
        check(9, 4'b0010, 1'b1);
        req = 4'b0000; last = 1'b1;
        step();
        check(7, 4'b0000, 1'b0);
        last = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule